// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a countdown watchdog that escalates in two steps. Software programs a load value, clears a halt bit and then keeps the timer alive by writing to a dedicated reload register. The counter steps down once per prescaler tick. If the counter expires before a reload arrives, the block sets a sticky first-timeout flag, reloads itself, and can raise a one-cycle management interrupt request. If the counter expires a second time while that flag is still set, the block issues a one-cycle system reset request. A no-reboot control can block that request, and a strap input can lock it on.

The second-timeout flag sits in flops that only the power-on reset clears. After the system reset that the watchdog itself caused, software can still see that the watchdog was the cause. All flags are write-one-to-clear. A parameter selects a narrow 8-bit timer-value register or a wide 16-bit one. Each variant has its own upper limit, and both have a common lower limit.

Top module: `wdt_two_stage`

Register map (address on `addr`): 0 timer value; 1 reload (a write reloads, a read returns the live count); 2 control; 3 status A; 4 status B; 5 no-reboot. Any other address reads 0.

## Requirements
- R1: After power-on reset, control reads 0x0800 (halted), the timer value and the live count both read the variant maximum (63 when narrow), both status registers read 0, no-reboot reads 0 with the strap low, and `tmo_irq` and `wdt_rst` are low.
- R2: While control bit 11 (halt) is 1, the live count does not change, except through a reload write.
- R3: While running, the count drops by one every PRESCALE clocks. After a reload write with load value L, the expiry happens at the clock edge (L+1)*PRESCALE cycles after the write edge, and the count then reads L again.
- R4: Any write to address 1 copies the stored timer value into the count. Writing address 0 alone leaves the live count unchanged until the next reload.
- R5: A written timer value below 4 is stored as 4, and a value above the variant maximum (63 narrow, 1023 wide) is stored as that maximum. The narrow variant takes only `wdata[7:0]`.
- R6: Status flags are set only by hardware. A write clears exactly the flags whose bit positions hold 1. Bits holding 0 leave their flags unchanged, so the two flags of status B clear with separate writes.
- R7: An expiry while status A bit 3 (first timeout) is 0 sets that bit. It pulses `tmo_irq` for one cycle, in the cycle after the expiry edge, only if control bit 13 (interrupt enable) is 1.
- R8: An expiry while status A bit 3 is 1 sets status B bit 1 (second timeout). If no-reboot is 0, it also pulses `wdt_rst` for exactly one cycle. No interrupt is raised on this expiry.
- R9: No-reboot (address 5, bit 0) set to 1 suppresses `wdt_rst`. A second expiry then sets status B bit 2 (boot status) instead. While `noreboot_strap` is 1, the bit reads 1 and a write of 0 does not clear it.
- R10: Status B bit 1 survives a low pulse on `rst_n`, while all other state returns to its reset value. Only `por_n` or a write-one-to-clear clears it.
- R11: Control bit 9 is a plain read/write bit that keeps its value across halt changes and expiries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the second-timeout flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| noreboot_strap | input | 1 | Forces and locks no-reboot when high |
| tmo_irq | output | 1 | One-cycle first-timeout interrupt request |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
A register write takes effect at the clock edge that samples `wr_en`. Read data is combinational, so every read checks state that is already settled. After a synchronising reload write at edge E, the bench predicts the count in every cycle as L minus the number of whole PRESCALE periods elapsed. It expects the `tmo_irq` or `wdt_rst` pulse exactly at edge E+(L+1)*PRESCALE, with both outputs low in every earlier cycle and again one cycle later. The bench drives inputs and samples outputs on falling edges, so each sample falls between the edge that produced it and the next one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    A_TMR  = 3'd0,
    A_RLD  = 3'd1,
    A_CTRL = 3'd2,
    A_STSA = 3'd3,
    A_STSB = 3'd4,
    A_NRB  = 3'd5
  } wdt_addr_e;

  // control register bit positions
  localparam int unsigned CTRL_AUX   = 9;
  localparam int unsigned CTRL_HALT  = 11;
  localparam int unsigned CTRL_IRQEN = 13;
  // status bit positions
  localparam int unsigned STSA_FIRST  = 3;
  localparam int unsigned STSB_SECOND = 1;
  localparam int unsigned STSB_BOOT   = 2;
  localparam int unsigned NRB_BIT     = 0;

  function automatic int unsigned tmr_max(bit wide);
    return wide ? 32'd1023 : 32'd63;
  endfunction

  function automatic int unsigned clamp_tmr(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned PC_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = run_i && !clear_i;
    end else begin : g_count
      logic [PC_W-1:0] pc_q;
      logic            wrap;
      assign wrap   = (pc_q == PC_W'(DIV - 1));
      assign tick_o = run_i && wrap && !clear_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc_q <= '0;
        else if (clear_i)  pc_q <= '0;
        else if (run_i)    pc_q <= wrap ? '0 : pc_q + 1'b1;
      end

      // R3: ticks are never back to back when dividing
      a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 6,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_i,
  input  logic             reload_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && !reload_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= RST_VAL;
    else if (reload_i || expire_o)   cnt_q <= load_i;
    else if (tick_i)                 cnt_q <= cnt_q - 1'b1;
  end

  // R4: a reload write loads the stored value
  a_r4_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> cnt_q == $past(load_i));
  // R3: expiry restarts from the stored value
  a_r3_expire_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_q == $past(load_i));

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic nrb_i,
  input  logic clr_first_i,
  input  logic clr_second_i,
  input  logic clr_boot_i,
  output logic first_o,
  output logic second_o,
  output logic boot_o,
  output logic irq_o,
  output logic rst_o
);
  logic sys_n;
  logic first_q, second_q, boot_q, irq_q, rst_q;
  logic stage2;

  assign sys_n  = rst_n & por_n;
  assign stage2 = expire_i && first_q;

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      first_q <= 1'b0;
      boot_q  <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
      if (clr_first_i) first_q <= 1'b0;
      if (clr_boot_i)  boot_q  <= 1'b0;
      if (expire_i && !first_q) begin
        first_q <= 1'b1;
        irq_q   <= irq_en_i;
      end
      if (stage2) begin
        if (nrb_i) boot_q <= 1'b1;
        else       rst_q  <= 1'b1;
      end
    end
  end

  // survives the watchdog's own reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            second_q <= 1'b0;
    else if (stage2)       second_q <= 1'b1;
    else if (clr_second_i) second_q <= 1'b0;
  end

  assign first_o  = first_q;
  assign second_o = second_q;
  assign boot_o   = boot_q;
  assign irq_o    = irq_q;
  assign rst_o    = rst_q;

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!sys_n)
    irq_q |-> $past(irq_en_i));
  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!sys_n)
    irq_q |-> first_q && !rst_q);
  a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (!sys_n)
    rst_q |=> !rst_q);
  a_r8_rst_with_flag: assert property (@(posedge clk) disable iff (!sys_n)
    rst_q |-> second_q);
  a_r9_nrb_blocks: assert property (@(posedge clk) disable iff (!sys_n)
    rst_q |-> !$past(nrb_i));
  a_r6_first_sticky: assert property (@(posedge clk) disable iff (!sys_n)
    first_q && !clr_first_i |=> first_q);
  a_r10_second_sticky: assert property (@(posedge clk) disable iff (!por_n)
    second_q && !clr_second_i |=> second_q);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter bit          WIDE_TMR = 1'b0,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned TMR_MIN  = 4
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        noreboot_strap,
  output logic        tmo_irq,
  output logic        wdt_rst
);
  import wdt_pkg::*;

  localparam int unsigned TMR_MAX = tmr_max(WIDE_TMR);
  localparam int unsigned CNT_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned REG_W   = WIDE_TMR ? 16 : 8;

  logic sys_n;
  assign sys_n = rst_n & por_n;

  // write decode
  logic wr_tmr, wr_rld, wr_ctrl, wr_stsa, wr_stsb, wr_nrb;
  assign wr_tmr  = wr_en && (addr == A_TMR);
  assign wr_rld  = wr_en && (addr == A_RLD);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stsa = wr_en && (addr == A_STSA);
  assign wr_stsb = wr_en && (addr == A_STSB);
  assign wr_nrb  = wr_en && (addr == A_NRB);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  // programmable state
  logic [CNT_W-1:0] load_q, load_d;
  logic             halt_q, aux_q, irq_en_q, nrb_q, nrb_eff;
  logic [REG_W-1:0] tmr_field;

  assign tmr_field = wdata[REG_W-1:0];
  assign load_d    = CNT_W'(clamp_tmr(32'(tmr_field), TMR_MIN, TMR_MAX));
  assign nrb_eff   = nrb_q | noreboot_strap;

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      load_q   <= CNT_W'(TMR_MAX);
      halt_q   <= 1'b1;
      aux_q    <= 1'b0;
      irq_en_q <= 1'b0;
      nrb_q    <= 1'b0;
    end else begin
      if (wr_tmr) load_q <= load_d;
      if (wr_ctrl) begin
        halt_q   <= wdata[CTRL_HALT];
        aux_q    <= wdata[CTRL_AUX];
        irq_en_q <= wdata[CTRL_IRQEN];
      end
      if (wr_nrb) nrb_q <= wdata[NRB_BIT] | noreboot_strap;
    end
  end

  // datapath
  logic             tick, expire;
  logic [CNT_W-1:0] cnt;
  logic             first_f, second_f, boot_f;

  wdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(sys_n), .run_i(!halt_q), .clear_i(wr_rld), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(TMR_MAX))) u_cnt (
    .clk(clk), .rst_n(sys_n), .load_i(load_q), .reload_i(wr_rld),
    .tick_i(tick), .cnt_o(cnt), .expire_o(expire)
  );

  wdt_escalate u_esc (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .expire_i(expire), .irq_en_i(irq_en_q), .nrb_i(nrb_eff),
    .clr_first_i (wr_stsa && wdata[STSA_FIRST]),
    .clr_second_i(wr_stsb && wdata[STSB_SECOND]),
    .clr_boot_i  (wr_stsb && wdata[STSB_BOOT]),
    .first_o(first_f), .second_o(second_f), .boot_o(boot_f),
    .irq_o(tmo_irq), .rst_o(wdt_rst)
  );

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_TMR:  rdata = 16'(load_q);
      A_RLD:  rdata = 16'(cnt);
      A_CTRL: begin
        rdata[CTRL_AUX]   = aux_q;
        rdata[CTRL_HALT]  = halt_q;
        rdata[CTRL_IRQEN] = irq_en_q;
      end
      A_STSA: rdata[STSA_FIRST] = first_f;
      A_STSB: begin
        rdata[STSB_SECOND] = second_f;
        rdata[STSB_BOOT]   = boot_f;
      end
      A_NRB:  rdata[NRB_BIT] = nrb_eff;
      default: rdata = '0;
    endcase
  end

  // R2: a halted timer keeps its count unless reloaded
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!sys_n)
    halt_q && !wr_rld |=> $stable(cnt));
  // R9: a strapped no-reboot never lets a reset out
  a_r9_strap_no_rst: assert property (@(posedge clk) disable iff (!sys_n)
    $past(noreboot_strap) |-> !wdt_rst);
  // R5: stored value always within limits
  a_r5_load_in_range: assert property (@(posedge clk) disable iff (!sys_n)
    32'(load_q) >= TMR_MIN && 32'(load_q) <= TMR_MAX);

endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int P     = 4;
  localparam int T_MIN = 4;
  localparam int T_MAX = 63;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        noreboot_strap = 1'b0;
  logic        tmo_irq, wdt_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_two_stage #(.WIDE_TMR(1'b0), .PRESCALE(P), .TMR_MIN(T_MIN)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .noreboot_strap(noreboot_strap),
    .tmo_irq(tmo_irq), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // call right after the synchronising reload write
  task automatic run_to_expiry(input int L, input logic e_irq, input logic e_rst, input string tag);
    logic [15:0] v;
    int bad = 0;
    logic [15:0] bad_act = 0, bad_exp = 0;
    for (int n = 0; n < (L + 1) * P; n++) begin
      if (n > 0) @(negedge clk);
      rd(3'd1, v);
      if (v !== 16'(L - n / P) || tmo_irq !== 1'b0 || wdt_rst !== 1'b0) begin
        if (bad == 0) begin bad_act = v; bad_exp = 16'(L - n / P); end
        bad++;
      end
    end
    chk({tag, " R3 countdown window"}, bad_act, bad_exp);
    if (bad != 0 && bad_act == bad_exp) begin
      errors++;
      $display("FAIL %s R3: early pulse actual 1 expected 0", tag);
    end
    @(negedge clk);
    chk({tag, " R7 irq at expiry"}, 16'(tmo_irq), 16'(e_irq));
    chk({tag, " R8 rst at expiry"}, 16'(wdt_rst), 16'(e_rst));
    rdchk({tag, " R3 reload at expiry"}, 3'd1, 16'(L));
    @(negedge clk);
    chk({tag, " R8 pulse width"}, 16'({tmo_irq, wdt_rst}), 16'd0);
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 3'd2, 16'h0800);
    rdchk("R1 timer value", 3'd0, 16'(T_MAX));
    rdchk("R1 count", 3'd1, 16'(T_MAX));
    rdchk("R1 status A", 3'd3, 16'h0000);
    rdchk("R1 status B", 3'd4, 16'h0000);
    rdchk("R1 no-reboot", 3'd5, 16'h0000);
    chk("R1 outputs", 16'({tmo_irq, wdt_rst}), 16'd0);
  endtask

  task automatic t_clamp;
    wr(3'd0, 16'd2);      rdchk("R5 clamp low", 3'd0, 16'(T_MIN));
    wr(3'd0, 16'd200);    rdchk("R5 clamp high", 3'd0, 16'(T_MAX));
    wr(3'd0, 16'h0105);   rdchk("R5 narrow field", 3'd0, 16'd5);
  endtask

  task automatic t_halt_reload;
    wr(3'd0, 16'd5);
    wr(3'd1, 16'd0);
    rdchk("R4 reload", 3'd1, 16'd5);
    wr(3'd0, 16'd10);
    rdchk("R4 deferred load", 3'd1, 16'd5);
    wr(3'd1, 16'd0);
    rdchk("R4 reload new value", 3'd1, 16'd10);
    repeat (30) @(negedge clk);
    rdchk("R2 halted hold", 3'd1, 16'd10);
    wr(3'd2, 16'h0A00);
    rdchk("R11 aux bit set", 3'd2, 16'h0A00);
  endtask

  task automatic t_first_irq;
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h2200);
    wr(3'd1, 16'd0);
    run_to_expiry(5, 1'b1, 1'b0, "first irq");
    rdchk("R7 first flag", 3'd3, 16'h0008);
    rdchk("R11 aux kept", 3'd2, 16'h2200);
    wr(3'd3, 16'h0000);
    rdchk("R6 write 0 keeps", 3'd3, 16'h0008);
    wr(3'd3, 16'h0008);
    rdchk("R6 write 1 clears", 3'd3, 16'h0000);
  endtask

  task automatic t_first_noirq;
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'd0);
    run_to_expiry(5, 1'b0, 1'b0, "first no irq");
    rdchk("R7 flag without irq", 3'd3, 16'h0008);
  endtask

  task automatic t_second_reset;
    wr(3'd0, 16'd4);
    wr(3'd2, 16'h2000);
    wr(3'd1, 16'd0);
    run_to_expiry(4, 1'b0, 1'b1, "second");
    rdchk("R8 second flag", 3'd4, 16'h0002);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rdchk("R10 survives reset", 3'd4, 16'h0002);
    rdchk("R10 status A cleared", 3'd3, 16'h0000);
    rdchk("R10 ctrl reset", 3'd2, 16'h0800);
    rdchk("R10 timer reset", 3'd0, 16'(T_MAX));
    wr(3'd4, 16'h0004);
    rdchk("R6 other bit keeps", 3'd4, 16'h0002);
    wr(3'd4, 16'h0002);
    rdchk("R10 w1c clears", 3'd4, 16'h0000);
  endtask

  task automatic t_noreboot;
    wr(3'd0, 16'd4);
    wr(3'd5, 16'h0001);
    rdchk("R9 no-reboot set", 3'd5, 16'h0001);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'd0);
    run_to_expiry(4, 1'b0, 1'b0, "nrb first");
    wr(3'd1, 16'd0);
    run_to_expiry(4, 1'b0, 1'b0, "R9 blocked");
    rdchk("R9 boot flag", 3'd4, 16'h0006);
    wr(3'd4, 16'h0004);
    rdchk("R6 boot cleared alone", 3'd4, 16'h0002);
    wr(3'd4, 16'h0002);
    rdchk("R6 second cleared alone", 3'd4, 16'h0000);
    wr(3'd2, 16'h0800);
    wr(3'd5, 16'h0000);
  endtask

  task automatic t_strap;
    noreboot_strap = 1'b1;
    wr(3'd5, 16'h0000);
    rdchk("R9 strap locked", 3'd5, 16'h0001);
    noreboot_strap = 1'b0;
    wr(3'd5, 16'h0000);
    rdchk("R9 unlocked clear", 3'd5, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clamp();
    t_halt_reload();
    t_first_irq();
    t_first_noirq();
    t_second_reset();
    t_noreboot();
    t_strap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule